// File: doc/BRIEF.md
# Battery Lifetime Statistics Recorder

This block keeps the long-term history of a single battery cell. It tracks the highest and lowest cell voltage and the highest and lowest cell temperature seen since reset, and it keeps three per-minute counters: total operating minutes, a running sum of cell temperature and a running sum of charge level. A measurement engine feeds it voltage and temperature samples with strobes. A separate timer supplies a one-minute tick, and a power-mode flag says whether the cell is in operational or sleep mode.

A host can overwrite any recorded value through a 16-bit write port with a 4-bit select. The wider counters are reached as two 16-bit halves. After a host write, tracking and counting continue from the written value. All counters clamp at their all-ones value instead of wrapping, and none of them advances in sleep mode.

Every result is registered. A sample, tick or write shows at the outputs after the next rising clock edge.

Top module: `life_stats_recorder`

## Requirements
- R1: After reset the outputs are: max_mv = 0x0000, min_mv = 0x1388, max_dk = 0x0980, min_dk = 0x0DCC, and run_min, temp_acc and level_acc are all zero.
- R2: A strobed voltage (volt_stb) or temperature (temp_stb) sample strictly above the stored maximum replaces that maximum. A sample equal to or below the maximum leaves it unchanged.
- R3: A strobed voltage or temperature sample strictly below the stored minimum replaces that minimum. A sample equal to or above the minimum leaves it unchanged.
- R4: A host write to a min/max register loads wr_data into it and takes priority over a sample in the same cycle. Later samples are compared against the written value.
- R5: When minute_tick is high and op_mode is 1, run_min increases by one. It holds at 0xFFFFFF once it reaches that value.
- R6: When minute_tick is high and op_mode is 1, temp_acc adds cell_temp and level_acc adds level. A sum that would pass 0xFFFFFFFF becomes 0xFFFFFFFF.
- R7: When op_mode is 0 (sleep), minute_tick changes none of run_min, temp_acc or level_acc.
- R8: A write to one half of a counter replaces only that half and leaves the other half as it was. For the high half of run_min, wr_data[7:0] is used. If a counter is written in the same cycle as an active tick, the write is applied and that counter does not add.
- R9: The wr_sel codes are: 0 max_mv, 1 min_mv, 2 max_dk, 3 min_dk, 4 run_min[15:0], 5 run_min[23:16], 6 temp_acc[15:0], 7 temp_acc[31:16], 8 level_acc[15:0], 9 level_acc[31:16]. Codes 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_stb | input | 1 | A new voltage sample is valid |
| volt_mv | input | 16 | Voltage sample in mV |
| temp_stb | input | 1 | A new temperature sample is valid |
| cell_temp | input | 16 | Current cell temperature in 0.1 K |
| level | input | 16 | Current charge level |
| minute_tick | input | 1 | One-cycle pulse once per minute |
| op_mode | input | 1 | 1 = operational, 0 = sleep |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Host write target (see R9) |
| wr_data | input | 16 | Host write data |
| max_mv | output | 16 | Highest recorded voltage |
| min_mv | output | 16 | Lowest recorded voltage |
| max_dk | output | 16 | Highest recorded temperature |
| min_dk | output | 16 | Lowest recorded temperature |
| run_min | output | 24 | Operating minutes |
| temp_acc | output | 32 | Temperature sum, added once per minute |
| level_acc | output | 32 | Charge-level sum, added once per minute |

## Verification
Every result here is due exactly one clock edge after the stimulus that causes it. This holds for tracker updates, host loads, counter increments and the saturation clamp, because each output comes straight from a register with no pipeline in front of it. The bench applies each stimulus 1 ns after a rising edge. It advances its own model at the next edge and compares all seven outputs 1 ns after that edge, so each comparison lands in the cycle its result is due and stays clear of the edge itself. Cases where a write and a sample or tick arrive in the same cycle are driven on purpose, so the priority is checked in that same single cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

   localparam int HOST_W = 16;
   localparam int SEL_W  = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_VMAX    = 4'd0,
      SEL_VMIN    = 4'd1,
      SEL_TMAX    = 4'd2,
      SEL_TMIN    = 4'd3,
      SEL_RUN_LO  = 4'd4,
      SEL_RUN_HI  = 4'd5,
      SEL_TACC_LO = 4'd6,
      SEL_TACC_HI = 4'd7,
      SEL_LACC_LO = 4'd8,
      SEL_LACC_HI = 4'd9
   } lsr_sel_e;

   typedef struct packed {
      logic [3:0] trk_ld;   // vmax, vmin, tmax, tmin (bit order = sel code)
      logic       run_wr;
      logic       tacc_wr;
      logic       lacc_wr;
      logic       hi_half;
   } lsr_wr_dec_t;

endpackage

// File: rtl/lsr_wr_decode.sv
module lsr_wr_decode
   import lsr_pkg::*;
(
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   output lsr_wr_dec_t      dec
);

   always_comb begin
      dec = '0;
      if (wr_en) begin
         case (wr_sel)
            SEL_VMAX:    dec.trk_ld[0] = 1'b1;
            SEL_VMIN:    dec.trk_ld[1] = 1'b1;
            SEL_TMAX:    dec.trk_ld[2] = 1'b1;
            SEL_TMIN:    dec.trk_ld[3] = 1'b1;
            SEL_RUN_LO:  dec.run_wr    = 1'b1;
            SEL_RUN_HI:  begin dec.run_wr  = 1'b1; dec.hi_half = 1'b1; end
            SEL_TACC_LO: dec.tacc_wr   = 1'b1;
            SEL_TACC_HI: begin dec.tacc_wr = 1'b1; dec.hi_half = 1'b1; end
            SEL_LACC_LO: dec.lacc_wr   = 1'b1;
            SEL_LACC_HI: begin dec.lacc_wr = 1'b1; dec.hi_half = 1'b1; end
            default:     dec = '0;
         endcase
      end
   end

endmodule

// File: rtl/lsr_extreme_track.sv
module lsr_extreme_track #(
   parameter int           W         = 16,
   parameter bit           TRACK_MAX = 1'b1,
   parameter logic [W-1:0] RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_stb,
   input  logic [W-1:0] smp_val,
   input  logic         ld_en,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] ext_q
);

   generate
      if (W < 2) begin : g_bad_w
         $error("lsr_extreme_track: W must be at least 2");
      end
   endgenerate

   logic take;

   generate
      if (TRACK_MAX) begin : g_max
         assign take = smp_stb && (smp_val > ext_q);
      end else begin : g_min
         assign take = smp_stb && (smp_val < ext_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ext_q <= RST_VAL;
      else if (ld_en) ext_q <= ld_val;
      else if (take)  ext_q <= smp_val;
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ext_q == $past(ld_val));  // R4

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !smp_stb) |=> $stable(ext_q));  // R2

   generate
      if (TRACK_MAX) begin : g_chk_max
         AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_en |=> ext_q >= $past(ext_q));  // R2
         AST_MAX_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_en && smp_stb && smp_val > ext_q) |=> ext_q == $past(smp_val));  // R2
      end else begin : g_chk_min
         AST_MIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            !ld_en |=> ext_q <= $past(ext_q));  // R3
         AST_MIN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (!ld_en && smp_stb && smp_val < ext_q) |=> ext_q == $past(smp_val));  // R3
      end
   endgenerate

endmodule

// File: rtl/lsr_sat_accum.sv
module lsr_sat_accum #(
   parameter int CNT_W  = 24,
   parameter int INC_W  = 1,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_en,
   input  logic [INC_W-1:0]  add_val,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt_q
);

   localparam int LO_W  = HALF_W;
   localparam int HI_W  = CNT_W - HALF_W;
   localparam int SUM_W = CNT_W + 1;

   generate
      if (CNT_W <= HALF_W || CNT_W > 2 * HALF_W) begin : g_bad_cnt
         $error("lsr_sat_accum: CNT_W must span exactly two halves");
      end
      if (INC_W < 1 || INC_W > CNT_W) begin : g_bad_inc
         $error("lsr_sat_accum: INC_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] add_res;
   logic [CNT_W-1:0] wr_res;

   // Increment variant: a unit step only has to spot all-ones;
   // a wide addend needs the carry out of an extended sum.
   generate
      if (INC_W == 1) begin : g_unit
         assign add_res = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(add_val);
      end else begin : g_wide
         logic [SUM_W-1:0] sum;
         assign sum     = {1'b0, cnt_q} + SUM_W'(add_val);
         assign add_res = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end
   endgenerate

   assign wr_res = wr_hi ? {wr_data[HI_W-1:0], cnt_q[LO_W-1:0]}
                         : {cnt_q[CNT_W-1:LO_W], wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wr_en)  cnt_q <= wr_res;
      else if (add_en) cnt_q <= add_res;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> cnt_q >= $past(cnt_q));  // R6

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (&cnt_q)) |=> (&cnt_q));  // R5

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !add_en) |=> $stable(cnt_q));  // R7

   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi) |=> cnt_q[LO_W-1:0] == $past(cnt_q[LO_W-1:0]));  // R8

   AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> cnt_q[CNT_W-1:LO_W] == $past(cnt_q[CNT_W-1:LO_W]));  // R8

   AST_WR_BEATS_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> cnt_q[LO_W-1:0] == $past(wr_data));  // R8

endmodule

// File: rtl/life_stats_recorder.sv
module life_stats_recorder
   import lsr_pkg::*;
#(
   parameter int                VOLT_W   = 16,
   parameter int                TEMP_W   = 16,
   parameter int                LVL_W    = 16,
   parameter int                RUN_W    = 24,
   parameter int                ACC_W    = 32,
   parameter logic [VOLT_W-1:0] VMAX_RST = 'h0000,
   parameter logic [VOLT_W-1:0] VMIN_RST = 'h1388,
   parameter logic [TEMP_W-1:0] TMAX_RST = 'h0980,
   parameter logic [TEMP_W-1:0] TMIN_RST = 'h0DCC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              volt_stb,
   input  logic [VOLT_W-1:0] volt_mv,
   input  logic              temp_stb,
   input  logic [TEMP_W-1:0] cell_temp,
   input  logic [LVL_W-1:0]  level,
   input  logic              minute_tick,
   input  logic              op_mode,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [HOST_W-1:0] wr_data,
   output logic [VOLT_W-1:0] max_mv,
   output logic [VOLT_W-1:0] min_mv,
   output logic [TEMP_W-1:0] max_dk,
   output logic [TEMP_W-1:0] min_dk,
   output logic [RUN_W-1:0]  run_min,
   output logic [ACC_W-1:0]  temp_acc,
   output logic [ACC_W-1:0]  level_acc
);

   generate
      if (VOLT_W > HOST_W || TEMP_W > HOST_W) begin : g_bad_trk
         $error("life_stats_recorder: tracked widths must fit one host word");
      end
      if (TEMP_W > ACC_W || LVL_W > ACC_W) begin : g_bad_acc
         $error("life_stats_recorder: accumulator narrower than its addend");
      end
   endgenerate

   lsr_wr_dec_t dec;
   logic        count_en;

   assign count_en = minute_tick & op_mode;

   lsr_wr_decode u_dec (
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .dec    (dec)
   );

   lsr_extreme_track #(.W(VOLT_W), .TRACK_MAX(1'b1), .RST_VAL(VMAX_RST)) u_vmax (
      .clk(clk), .rst_n(rst_n), .smp_stb(volt_stb), .smp_val(volt_mv),
      .ld_en(dec.trk_ld[0]), .ld_val(wr_data[VOLT_W-1:0]), .ext_q(max_mv));

   lsr_extreme_track #(.W(VOLT_W), .TRACK_MAX(1'b0), .RST_VAL(VMIN_RST)) u_vmin (
      .clk(clk), .rst_n(rst_n), .smp_stb(volt_stb), .smp_val(volt_mv),
      .ld_en(dec.trk_ld[1]), .ld_val(wr_data[VOLT_W-1:0]), .ext_q(min_mv));

   lsr_extreme_track #(.W(TEMP_W), .TRACK_MAX(1'b1), .RST_VAL(TMAX_RST)) u_tmax (
      .clk(clk), .rst_n(rst_n), .smp_stb(temp_stb), .smp_val(cell_temp),
      .ld_en(dec.trk_ld[2]), .ld_val(wr_data[TEMP_W-1:0]), .ext_q(max_dk));

   lsr_extreme_track #(.W(TEMP_W), .TRACK_MAX(1'b0), .RST_VAL(TMIN_RST)) u_tmin (
      .clk(clk), .rst_n(rst_n), .smp_stb(temp_stb), .smp_val(cell_temp),
      .ld_en(dec.trk_ld[3]), .ld_val(wr_data[TEMP_W-1:0]), .ext_q(min_dk));

   lsr_sat_accum #(.CNT_W(RUN_W), .INC_W(1), .HALF_W(HOST_W)) u_run (
      .clk(clk), .rst_n(rst_n), .add_en(count_en), .add_val(1'b1),
      .wr_en(dec.run_wr), .wr_hi(dec.hi_half), .wr_data(wr_data), .cnt_q(run_min));

   lsr_sat_accum #(.CNT_W(ACC_W), .INC_W(TEMP_W), .HALF_W(HOST_W)) u_tacc (
      .clk(clk), .rst_n(rst_n), .add_en(count_en), .add_val(cell_temp),
      .wr_en(dec.tacc_wr), .wr_hi(dec.hi_half), .wr_data(wr_data), .cnt_q(temp_acc));

   lsr_sat_accum #(.CNT_W(ACC_W), .INC_W(LVL_W), .HALF_W(HOST_W)) u_lacc (
      .clk(clk), .rst_n(rst_n), .add_en(count_en), .add_val(level),
      .wr_en(dec.lacc_wr), .wr_hi(dec.hi_half), .wr_data(wr_data), .cnt_q(level_acc));

   AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec.trk_ld, dec.run_wr, dec.tacc_wr, dec.lacc_wr}));  // R9

   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_mode && !wr_en) |=> ($stable(run_min) && $stable(temp_acc) && $stable(level_acc)));  // R7

   AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !wr_en && !(&run_min)) |=> run_min == $past(run_min) + 1'b1);  // R5

   AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel > 4'd9 && !volt_stb && !temp_stb && !minute_tick)
      |=> ($stable(max_mv) && $stable(min_mv) && $stable(max_dk) && $stable(min_dk)
           && $stable(run_min) && $stable(temp_acc) && $stable(level_acc)));  // R9

endmodule

// File: tb/tb_life_stats_recorder.sv
`timescale 1ns/1ps
module tb_life_stats_recorder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        volt_stb = 1'b0, temp_stb = 1'b0, minute_tick = 1'b0, op_mode = 1'b0, wr_en = 1'b0;
   logic [15:0] volt_mv = '0, cell_temp = '0, level = '0, wr_data = '0;
   logic [3:0]  wr_sel = '0;
   logic [15:0] max_mv, min_mv, max_dk, min_dk;
   logic [23:0] run_min;
   logic [31:0] temp_acc, level_acc;

   int checks = 0;
   int errors = 0;

   logic [15:0] e_vmax, e_vmin, e_tmax, e_tmin;
   logic [23:0] e_run;
   logic [31:0] e_tacc, e_lacc;

   always #2.5 clk = ~clk;

   life_stats_recorder dut (
      .clk(clk), .rst_n(rst_n), .volt_stb(volt_stb), .volt_mv(volt_mv),
      .temp_stb(temp_stb), .cell_temp(cell_temp), .level(level),
      .minute_tick(minute_tick), .op_mode(op_mode), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .max_mv(max_mv), .min_mv(min_mv),
      .max_dk(max_dk), .min_dk(min_dk), .run_min(run_min),
      .temp_acc(temp_acc), .level_acc(level_acc));

   function automatic logic [31:0] sat_add(input logic [31:0] cur, input logic [31:0] inc,
                                           input logic [32:0] lim);
      logic [32:0] s;
      s = {1'b0, cur} + {1'b0, inc};
      return (s > lim) ? lim[31:0] : s[31:0];
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2 max_mv", 32'(max_mv), 32'(e_vmax));
      chk("R3 min_mv", 32'(min_mv), 32'(e_vmin));
      chk("R2 max_dk", 32'(max_dk), 32'(e_tmax));
      chk("R3 min_dk", 32'(min_dk), 32'(e_tmin));
      chk("R5 run_min", 32'(run_min), 32'(e_run));
      chk("R6 temp_acc", temp_acc, e_tacc);
      chk("R6 level_acc", level_acc, e_lacc);
   endtask

   // Drive one cycle of stimulus, advance the model, compare after the edge.
   task automatic step(input logic vs, input logic [15:0] vv, input logic ts,
                       input logic [15:0] tv, input logic [15:0] lv, input logic tk,
                       input logic op, input logic we, input logic [3:0] sel,
                       input logic [15:0] wd);
      logic cnt;
      volt_stb = vs; volt_mv = vv; temp_stb = ts; cell_temp = tv; level = lv;
      minute_tick = tk; op_mode = op; wr_en = we; wr_sel = sel; wr_data = wd;
      cnt = tk && op;
      if (we && sel == 4'd0) e_vmax = wd; else if (vs && vv > e_vmax) e_vmax = vv;
      if (we && sel == 4'd1) e_vmin = wd; else if (vs && vv < e_vmin) e_vmin = vv;
      if (we && sel == 4'd2) e_tmax = wd; else if (ts && tv > e_tmax) e_tmax = tv;
      if (we && sel == 4'd3) e_tmin = wd; else if (ts && tv < e_tmin) e_tmin = tv;
      if (we && sel == 4'd4)      e_run = {e_run[23:16], wd};
      else if (we && sel == 4'd5) e_run = {wd[7:0], e_run[15:0]};
      else if (cnt)               e_run = 24'(sat_add(32'(e_run), 32'd1, 33'h0_00FF_FFFF));
      if (we && sel == 4'd6)      e_tacc = {e_tacc[31:16], wd};
      else if (we && sel == 4'd7) e_tacc = {wd, e_tacc[15:0]};
      else if (cnt)               e_tacc = sat_add(e_tacc, 32'(tv), 33'h0_FFFF_FFFF);
      if (we && sel == 4'd8)      e_lacc = {e_lacc[31:16], wd};
      else if (we && sel == 4'd9) e_lacc = {wd, e_lacc[15:0]};
      else if (cnt)               e_lacc = sat_add(e_lacc, 32'(lv), 33'h0_FFFF_FFFF);
      @(posedge clk);
      #1;
      check_all();
   endtask

   task automatic wr(input logic [3:0] sel, input logic [15:0] wd);
      step(1'b0, 16'd0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b1, 1'b1, sel, wd);
   endtask

   task automatic tick(input logic op, input logic [15:0] tv, input logic [15:0] lv);
      step(1'b0, 16'd0, 1'b0, tv, lv, 1'b1, op, 1'b0, 4'd0, 16'd0);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0417));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      e_vmax = 16'h0000; e_vmin = 16'h1388; e_tmax = 16'h0980; e_tmin = 16'h0DCC;
      e_run = '0; e_tacc = '0; e_lacc = '0;
      // R1 reset state
      chk("R1 reset max_mv", 32'(max_mv), 32'h0000);
      chk("R1 reset min_mv", 32'(min_mv), 32'h1388);
      chk("R1 reset max_dk", 32'(max_dk), 32'h0980);
      chk("R1 reset min_dk", 32'(min_dk), 32'h0DCC);
      chk("R1 reset run_min", 32'(run_min), 32'h0);
      chk("R1 reset accumulators", temp_acc | level_acc, 32'h0);

      // R2 / R3 tracking, including an equal sample
      step(1'b1, 16'd3700, 1'b1, 16'h0BA6, 16'd0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd0);
      chk("R2 first voltage sample", 32'(max_mv), 32'd3700);
      step(1'b1, 16'd3600, 1'b0, 16'h0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd0);
      chk("R3 lower voltage sample", 32'(min_mv), 32'd3600);
      step(1'b1, 16'd3700, 1'b0, 16'h0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd0);
      chk("R2 equal sample holds", 32'(max_mv), 32'd3700);

      // R4 write beats same-cycle sample, tracking resumes from written value
      step(1'b1, 16'd4000, 1'b0, 16'h0, 16'd0, 1'b0, 1'b1, 1'b1, 4'd0, 16'd100);
      chk("R4 write beats sample", 32'(max_mv), 32'd100);
      step(1'b1, 16'd200, 1'b0, 16'h0, 16'd0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd0);
      chk("R4 tracking resumes", 32'(max_mv), 32'd200);
      wr(4'd3, 16'h0A00);
      chk("R4 min temperature load", 32'(min_dk), 32'h0A00);

      // R5 run counter saturation; R8 high half uses bits 7:0
      wr(4'd4, 16'hFFFE);
      wr(4'd5, 16'hABFF);
      chk("R8 run high half from data bits 7:0", 32'(run_min), 32'h00FF_FFFE);
      tick(1'b1, 16'd0, 16'd0);
      chk("R5 run reaches max", 32'(run_min), 32'h00FF_FFFF);
      tick(1'b1, 16'd0, 16'd0);
      chk("R5 run holds at max", 32'(run_min), 32'h00FF_FFFF);

      // R6 accumulator clamps instead of wrapping
      wr(4'd7, 16'hFFFF);
      wr(4'd6, 16'hFFF0);
      wr(4'd9, 16'h0000);
      wr(4'd8, 16'h0005);
      tick(1'b1, 16'h0020, 16'd50);
      chk("R6 temp_acc clamps", temp_acc, 32'hFFFF_FFFF);
      chk("R6 level_acc adds", level_acc, 32'd55);

      // R7 sleep mode freezes all counters
      tick(1'b0, 16'h0BA6, 16'd80);
      chk("R7 sleep keeps level_acc", level_acc, 32'd55);
      chk("R7 sleep keeps run_min", 32'(run_min), 32'h00FF_FFFF);

      // R8 write and tick in the same cycle: write wins, other half kept
      step(1'b0, 16'd0, 1'b0, 16'd7, 16'd9, 1'b1, 1'b1, 1'b1, 4'd9, 16'h0001);
      chk("R8 write beats tick", level_acc, 32'h0001_0037);
      chk("R6 unwritten acc adds same cycle", temp_acc, 32'hFFFF_FFFF);

      // R9 unused select codes change nothing
      for (int c = 10; c < 16; c++) begin
         wr(4'(c), 16'h1234);
      end
      chk("R9 unused code keeps max_mv", 32'(max_mv), 32'd200);
      chk("R9 unused code keeps level_acc", level_acc, 32'h0001_0037);

      // Constrained random phase
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] rsel;
         logic [15:0] rwd;
         rsel = 4'($urandom_range(0, 15));
         rwd  = 16'($urandom);
         if (rsel < 4'd4) rwd = 16'($urandom_range(2300, 5200));
         step(($urandom_range(0, 3) == 0), 16'($urandom_range(2300, 5200)),
              ($urandom_range(0, 3) == 0), 16'($urandom_range(16'h0900, 16'h0E00)),
              16'($urandom_range(0, 100)), ($urandom_range(0, 3) == 0),
              ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), rsel, rwd);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule